// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block steers device interrupt requests to as many as four processors. Devices raise and drop requests through two pulse vectors, one that sets bits and one that clears bits in a shared 64-bit pending vector. Each processor owns a 64-bit enable mask. A processor's active vector is the bitwise AND of its own mask with the pending vector, and it is recomputed continuously. The processor's level interrupt line stays high for as long as that active vector is non-zero. A second line carries a real-time-clock interrupt. An external tick raises this line, and software drops it by writing an acknowledge bit into a miscellaneous register.

Software reaches the block through a single-beat 64-bit register port. Each request carries the ID of the requesting processor. The register index is the byte offset divided by 64. The response arrives one cycle after the request, with read data and an error flag. Full 64-bit accesses are the only legal ones. Writes to read-only state set the error flag, as does any access to a register this block does not implement.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask and the pending vector are zero, all `dev_irq` bits and `rtc_irq` are low, and `rsp_valid` and `rsp_err` are low.
- R2: A bit set in `pend_set` sets that pending bit, and a bit set in `pend_clr` clears it. When the same bit is in both, the clear wins. The pending vector is read at index 12.
- R3: The mask of CPU 0, 1, 2 and 3 is read and written at index 8, 9, 24 and 25. The active vector of CPU 0, 1, 2 and 3 is read at index 10, 11, 26 and 27, and it always equals that CPU's mask ANDed with the pending vector.
- R4: `dev_irq[i]` is high exactly when CPU i's active vector is non-zero. It follows a mask write or a pending change on the same clock edge that updates that state, so it can rise as well as fall after a mask write.
- R5: A clear that removes the last active bit of a CPU drops only that CPU's line. Other CPUs that still have active bits keep their lines high.
- R6: A read of the miscellaneous register (index 2) returns the requester's 2-bit ID in bits [1:0] and the current `rtc_irq` in bit 4. All other bits are zero.
- R7: An `rtc_tick` pulse raises `rtc_irq`. A write to index 2 with data bit 4 set lowers it without an error. If a tick and such a write arrive together, the line stays high.
- R8: A write to index 2 with data bit 4 clear returns an error and leaves `rtc_irq` unchanged.
- R9: Any access with `req_size` other than 3 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) returns an error with zero read data and changes no state.
- R10: Writes to an active register, to the pending register or to the general register (index 0) return an error and change no state.
- R11: A read of the general register (index 0) returns zero without an error.
- R12: Reads and writes at any index not listed above return an error with zero data. This includes indexes 1, 4 to 7, 13 to 19 and every index above 27.
- R13: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In all other cycles `rsp_valid` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte offset; bits [10:6] select the register |
| req_size | input | 2 | Access size code (3 = 64-bit) |
| req_cpu | input | 2 | ID of the requesting CPU |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 64 | Read data, zero on error or write |
| rsp_err | output | 1 | Request rejected |
| pend_set | input | 64 | Pulse vector setting pending bits |
| pend_clr | input | 64 | Pulse vector clearing pending bits |
| rtc_tick | input | 1 | Pulse raising the real-time-clock interrupt |
| dev_irq | output | 4 | Per-CPU device interrupt level |
| rtc_irq | output | 1 | Real-time-clock interrupt level |

## Verification
The bench targets the cases where the line state depends on the order of events. The first is a mask write that lowers a line that is already high; a design that latches the line would leave it stuck. The second is a clear that empties one CPU's active vector while other CPUs keep theirs; a design that clears lines globally would drop all of them. Simultaneous set and clear on the same bit, and a tick that collides with an acknowledge, expose the wrong priority as a lost request or a lost tick. Narrow accesses, writes to the read-only registers and an acknowledge write without bit 4 are each followed by read-back at full size, which catches an error flag that is raised while the state is still updated anyway.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_GEN,
      RK_MISC,
      RK_MASK,
      RK_ACTIVE,
      RK_PEND
   } reg_kind_e;

   localparam int MAX_CPU       = 4;
   localparam int REG_STRIDE_LG = 6;
   localparam int IDX_GEN       = 0;
   localparam int IDX_MISC      = 2;
   localparam int IDX_PEND      = 12;
   localparam int MISC_ACK_BIT  = 4;
   localparam logic [1:0] SIZE_FULL = 2'd3;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
   import irq_router_pkg::*;
#(
   parameter int IDXW = 5,
   parameter int NCPU = 4
) (
   input  logic [IDXW-1:0] idx_i,
   input  logic            write_i,
   input  logic [1:0]      size_i,
   input  logic            ack_bit_i,
   output reg_kind_e       kind_o,
   output logic [1:0]      cpu_o,
   output logic            err_o
);

   localparam int LOWW = 5;

   logic            hi_zero;
   logic [LOWW-1:0] low;
   logic            legal;
   logic            cpu_ok;

   generate
      if (IDXW < LOWW) begin : g_bad_idxw
         $error("irq_csr_decode: index width must be at least 5");
      end
      if (IDXW > LOWW) begin : g_hi
         assign hi_zero = ~|idx_i[IDXW-1:LOWW];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign low    = idx_i[LOWW-1:0];
   assign cpu_o  = {low[4], low[0]};
   assign cpu_ok = (32'(cpu_o) < NCPU);

   always_comb begin
      kind_o = RK_NONE;
      legal  = 1'b0;
      if (hi_zero) begin
         if (low[3:1] == 3'b100) begin
            kind_o = RK_MASK;
            legal  = cpu_ok;
         end else if (low[3:1] == 3'b101) begin
            kind_o = RK_ACTIVE;
            legal  = cpu_ok && !write_i;
         end else if (low == LOWW'(IDX_GEN)) begin
            kind_o = RK_GEN;
            legal  = !write_i;
         end else if (low == LOWW'(IDX_MISC)) begin
            kind_o = RK_MISC;
            legal  = !write_i || ack_bit_i;
         end else if (low == LOWW'(IDX_PEND)) begin
            kind_o = RK_PEND;
            legal  = !write_i;
         end
      end
   end

   assign err_o = !legal || (size_i != SIZE_FULL);

endmodule

// File: rtl/irq_pend_vec.sv
module irq_pend_vec #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q | set_i) & ~clr_i;
   end

   assign pend_o = pend_q;

   // R2
   clr_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));

   // R2
   set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & ~clr_i)) |=>
         ((pend_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

endmodule

// File: rtl/irq_cpu_route.sv
module irq_cpu_route #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] pend_i,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] active_o,
   output logic         irq_o
);

   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_en_i) mask_q <= wdata_i;
   end

   assign mask_o   = mask_q;
   assign active_o = mask_q & pend_i;
   assign irq_o    = |active_o;

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (mask_q == $past(wdata_i)));

   // R4
   irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(mask_q) && $stable(pend_i)) |-> $stable(irq_o));

endmodule

// File: rtl/irq_rtc_line.sv
module irq_rtc_line (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ack_i,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      irq_q <= 1'b0;
      else if (tick_i) irq_q <= 1'b1;
      else if (ack_i)  irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   // R7
   tick_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> irq_q);

   // R7
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !tick_i) |=> !irq_q);

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int DW   = 64,
   parameter int NCPU = 4,
   parameter int AW   = 11,
   parameter int CIDW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [1:0]      req_size,
   input  logic [CIDW-1:0] req_cpu,
   input  logic [DW-1:0]   req_wdata,
   output logic            rsp_valid,
   output logic [DW-1:0]   rsp_rdata,
   output logic            rsp_err,
   input  logic [DW-1:0]   pend_set,
   input  logic [DW-1:0]   pend_clr,
   input  logic            rtc_tick,
   output logic [NCPU-1:0] dev_irq,
   output logic            rtc_irq
);

   localparam int IDXW = AW - REG_STRIDE_LG;

   generate
      if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
         $error("irq_router: NCPU must be 1..4");
      end
      if (DW <= MISC_ACK_BIT) begin : g_bad_dw
         $error("irq_router: data width too small for the acknowledge bit");
      end
      if (CIDW != 2) begin : g_bad_cidw
         $error("irq_router: CPU ID width must be 2");
      end
   endgenerate

   reg_kind_e       kind;
   logic [1:0]      sel_cpu;
   logic            dec_err;
   logic [DW-1:0]   pend;
   logic [DW-1:0]   mask_a   [MAX_CPU];
   logic [DW-1:0]   active_a [MAX_CPU];
   logic            wr_ok;
   logic            rtc_ack;
   logic [DW-1:0]   rdata_n;
   logic            unused_addr_low;

   assign unused_addr_low = ^req_addr[REG_STRIDE_LG-1:0];

   irq_csr_decode #(
      .IDXW (IDXW),
      .NCPU (NCPU)
   ) u_dec (
      .idx_i     (req_addr[AW-1:REG_STRIDE_LG]),
      .write_i   (req_write),
      .size_i    (req_size),
      .ack_bit_i (req_wdata[MISC_ACK_BIT]),
      .kind_o    (kind),
      .cpu_o     (sel_cpu),
      .err_o     (dec_err)
   );

   assign wr_ok   = req_valid && req_write && !dec_err;
   assign rtc_ack = wr_ok && (kind == RK_MISC);

   irq_pend_vec #(.W(DW)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pend_set),
      .clr_i  (pend_clr),
      .pend_o (pend)
   );

   genvar g;
   generate
      for (g = 0; g < MAX_CPU; g++) begin : g_cpu
         if (g < NCPU) begin : g_live
            logic wr_this;
            assign wr_this = wr_ok && (kind == RK_MASK) && (sel_cpu == 2'(g));
            irq_cpu_route #(.W(DW)) u_route (
               .clk      (clk),
               .rst_n    (rst_n),
               .wr_en_i  (wr_this),
               .wdata_i  (req_wdata),
               .pend_i   (pend),
               .mask_o   (mask_a[g]),
               .active_o (active_a[g]),
               .irq_o    (dev_irq[g])
            );
         end else begin : g_absent
            assign mask_a[g]   = '0;
            assign active_a[g] = '0;
         end
      end
   endgenerate

   irq_rtc_line u_rtc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (rtc_tick),
      .ack_i  (rtc_ack),
      .irq_o  (rtc_irq)
   );

   always_comb begin
      rdata_n = '0;
      if (!dec_err && !req_write) begin
         case (kind)
            RK_MISC: begin
               rdata_n[MISC_ACK_BIT] = rtc_irq;
               rdata_n[1:0]          = req_cpu;
            end
            RK_MASK:   rdata_n = mask_a[sel_cpu];
            RK_ACTIVE: rdata_n = active_a[sel_cpu];
            RK_PEND:   rdata_n = pend;
            default:   rdata_n = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= req_valid ? rdata_n : '0;
      end
   end

   // R13
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R13
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err));

   // R9
   narrow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != SIZE_FULL) |=> (rsp_err && rsp_rdata == '0));

   // R8
   misc_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_wdata[MISC_ACK_BIT] && !rtc_tick &&
       req_addr[AW-1:REG_STRIDE_LG] == IDXW'(IDX_MISC))
      |=> (rsp_err && rtc_irq == $past(rtc_irq)));

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'd3;
   logic [1:0]    req_cpu = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_err;
   logic [DW-1:0] pend_set = '0;
   logic [DW-1:0] pend_clr = '0;
   logic          rtc_tick = 1'b0;
   logic [3:0]    dev_irq;
   logic          rtc_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] m_pend;
   logic [DW-1:0] m_mask [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_router dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_cpu(req_cpu),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .pend_set(pend_set), .pend_clr(pend_clr),
      .rtc_tick(rtc_tick), .dev_irq(dev_irq), .rtc_irq(rtc_irq)
   );

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int mask_idx(int c);
      return 8 + (c % 2) + 16 * (c / 2);
   endfunction

   function automatic logic [3:0] exp_irq();
      logic [3:0] r;
      for (int c = 0; c < 4; c++) r[c] = |(m_mask[c] & m_pend);
      return r;
   endfunction

   task automatic acc(input logic wr, input int idx, input logic [1:0] sz,
                      input logic [1:0] cpu, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output logic er);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = AW'(idx << 6);
      req_size  = sz;
      req_cpu   = cpu;
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      rd = rsp_rdata;
      er = rsp_err;
   endtask

   task automatic pulse(input logic [DW-1:0] s, input logic [DW-1:0] c);
      @(negedge clk);
      pend_set = s;
      pend_clr = c;
      @(negedge clk);
      pend_set = '0;
      pend_clr = '0;
      m_pend = (m_pend | s) & ~c;
   endtask

   task automatic t_reset();
      logic [DW-1:0] rd; logic er;
      chk("R1 dev_irq", DW'(dev_irq), '0);
      chk("R1 rtc_irq", DW'(rtc_irq), '0);
      chk("R1 rsp_valid", DW'(rsp_valid), '0);
      acc(1'b0, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R1 pending zero", rd, '0);
      acc(1'b0, 25, 2'd3, 2'd0, '0, rd, er);
      chk("R1 mask3 zero", rd, '0);
      chk("R1 err", DW'(er), '0);
   endtask

   task automatic t_pending();
      logic [DW-1:0] rd; logic er;
      pulse(64'hF0F0, '0);
      acc(1'b0, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R2 set", rd, 64'hF0F0);
      pulse(64'h000F, 64'h0F01);
      acc(1'b0, 12, 2'd3, 2'd1, '0, rd, er);
      chk("R2 clear wins", rd, 64'hF0FE);
      pulse('0, '1);
      acc(1'b0, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R2 clear all", rd, '0);
   endtask

   task automatic t_route();
      logic [DW-1:0] rd; logic er;
      logic [DW-1:0] vals [4];
      vals[0] = 64'h00FF; vals[1] = 64'hFF00;
      vals[2] = 64'h1_0000_0000; vals[3] = 64'h0;
      for (int c = 0; c < 4; c++) begin
         acc(1'b1, mask_idx(c), 2'd3, 2'd0, vals[c], rd, er);
         m_mask[c] = vals[c];
      end
      for (int c = 0; c < 4; c++) begin
         acc(1'b0, mask_idx(c), 2'd3, 2'(c), '0, rd, er);
         chk("R3 mask readback", rd, vals[c]);
      end
      chk("R4 idle lines", DW'(dev_irq), '0);
      pulse(64'h0101, '0);
      chk("R4 set raises", DW'(dev_irq), DW'(exp_irq()));
      for (int c = 0; c < 4; c++) begin
         acc(1'b0, mask_idx(c) + 2, 2'd3, 2'd0, '0, rd, er);
         chk("R3 active", rd, m_mask[c] & m_pend);
      end
      pulse(64'h1_0000_0000, '0);
      chk("R4 cpu2 raised", DW'(dev_irq), 64'b0111);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(25 << 6);
      req_size = 2'd3; req_wdata = 64'h1;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      m_mask[3] = 64'h1;
      chk("R4 mask write raises same edge", DW'(dev_irq), 64'b1111);
      acc(1'b1, 25, 2'd3, 2'd0, '0, rd, er);
      m_mask[3] = '0;
      chk("R4 mask write lowers", DW'(dev_irq), 64'b0111);
   endtask

   task automatic t_clear();
      pulse('0, 64'h0001);
      chk("R5 only cpu0 drops", DW'(dev_irq), 64'b0110);
      pulse('0, 64'h0100);
      chk("R5 cpu1 drops", DW'(dev_irq), 64'b0100);
      pulse('0, 64'h1_0000_0000);
      chk("R5 all low", DW'(dev_irq), DW'(exp_irq()));
   endtask

   task automatic t_misc();
      logic [DW-1:0] rd; logic er;
      for (int c = 0; c < 4; c++) begin
         acc(1'b0, 2, 2'd3, 2'(c), '0, rd, er);
         chk("R6 misc id", rd, DW'(c));
      end
   endtask

   task automatic t_rtc();
      logic [DW-1:0] rd; logic er;
      @(negedge clk); rtc_tick = 1'b1;
      @(negedge clk); rtc_tick = 1'b0;
      chk("R7 tick raises", DW'(rtc_irq), 64'd1);
      acc(1'b0, 2, 2'd3, 2'd2, '0, rd, er);
      chk("R6 misc shows rtc", rd, 64'h12);
      acc(1'b1, 2, 2'd3, 2'd0, 64'h10, rd, er);
      chk("R7 ack err", DW'(er), '0);
      chk("R7 ack lowers", DW'(rtc_irq), '0);
      @(negedge clk);
      rtc_tick = 1'b1; req_valid = 1'b1; req_write = 1'b1;
      req_addr = AW'(2 << 6); req_size = 2'd3; req_wdata = 64'h10;
      @(negedge clk);
      rtc_tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      chk("R7 tick beats ack", DW'(rtc_irq), 64'd1);
      acc(1'b1, 2, 2'd3, 2'd0, 64'h01, rd, er);
      chk("R8 no-ack err", DW'(er), 64'd1);
      chk("R8 rtc held", DW'(rtc_irq), 64'd1);
      acc(1'b1, 2, 2'd3, 2'd0, 64'hFFFF, rd, er);
      chk("R7 ack again", DW'(rtc_irq), '0);
   endtask

   task automatic t_size();
      logic [DW-1:0] rd; logic er;
      for (int s = 0; s < 3; s++) begin
         acc(1'b1, 8, 2'(s), 2'd0, 64'hDEAD, rd, er);
         chk("R9 narrow write err", DW'(er), 64'd1);
      end
      acc(1'b0, 8, 2'd3, 2'd0, '0, rd, er);
      chk("R9 mask unchanged", rd, m_mask[0]);
      acc(1'b0, 8, 2'd2, 2'd0, '0, rd, er);
      chk("R9 narrow read data", rd, '0);
      chk("R9 narrow read err", DW'(er), 64'd1);
   endtask

   task automatic t_ro();
      logic [DW-1:0] rd; logic er;
      pulse(64'h0003, '0);
      acc(1'b1, 10, 2'd3, 2'd0, '0, rd, er);
      chk("R10 active write err", DW'(er), 64'd1);
      acc(1'b1, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R10 pending write err", DW'(er), 64'd1);
      acc(1'b1, 0, 2'd3, 2'd0, '1, rd, er);
      chk("R10 general write err", DW'(er), 64'd1);
      acc(1'b0, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R10 pending kept", rd, m_pend);
      chk("R10 line kept", DW'(dev_irq), DW'(exp_irq()));
   endtask

   task automatic t_gen();
      logic [DW-1:0] rd; logic er;
      acc(1'b0, 0, 2'd3, 2'd3, '0, rd, er);
      chk("R11 general zero", rd, '0);
      chk("R11 general ok", DW'(er), '0);
   endtask

   task automatic t_unsup();
      logic [DW-1:0] rd; logic er;
      int idxs [14] = '{1, 4, 5, 6, 7, 13, 14, 15, 16, 19, 20, 23, 28, 31};
      for (int k = 0; k < 14; k++) begin
         acc(1'b0, idxs[k], 2'd3, 2'd0, '0, rd, er);
         chk("R12 unsupported err", DW'(er), 64'd1);
         chk("R12 unsupported data", rd, '0);
      end
      acc(1'b1, 1, 2'd3, 2'd0, 64'h55, rd, er);
      chk("R12 unsupported write err", DW'(er), 64'd1);
   endtask

   task automatic t_valid();
      logic [DW-1:0] rd; logic er;
      acc(1'b0, 12, 2'd3, 2'd0, '0, rd, er);
      chk("R13 valid during response", DW'(rsp_valid), 64'd1);
      acc(1'b0, 1, 2'd3, 2'd0, '0, rd, er);
      @(negedge clk);
      chk("R13 idle valid", DW'(rsp_valid), '0);
      chk("R13 idle err", DW'(rsp_err), '0);
   endtask

   initial begin
      m_pend = '0;
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pending();
      t_route();
      t_clear();
      t_misc();
      t_rtc();
      t_size();
      t_ro();
      t_gen();
      t_unsup();
      t_valid();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule